// File: doc/BRIEF.md
# Overlapping Window Smart Buffer

This block sits between an ordered element stream, typically fed by a DMA engine, and a group of parallel consumers. Consumer number k needs four neighbouring array elements, starting with element k. Neighbouring consumers share three of those four elements. The block therefore reads every element from the stream exactly once. It keeps the last few elements in a short register chain and forms each window from the chain plus the element just accepted.

Software sets the number of windows on a run-time input. It then raises an enable level. The block fills its chain and emits one window, tagged with its consumer index, for every accepted element after the warm-up. It stops taking input after the last element it needs and raises a done flag once the final window has been taken. For N windows the block takes N+3 elements. Dropping the enable returns the block to idle, ready for a new run.

Top module: `win_smart_buffer`

## Requirements
- R1: Right after reset, `out_valid`, `done` and `in_ready` are all low.
- R2: While `go` is low, `in_ready` and `out_valid` stay low, so no element is taken and no window appears, whatever `in_valid` does.
- R3: No window is emitted before four elements of the current run have been accepted. The first window appears in the cycle after the fourth element is accepted.
- R4: The window tagged k holds stream elements k, k+1, k+2 and k+3 of the run. Element k sits in bits [DW-1:0], and each following element sits in the next DW-bit slice up.
- R5: `out_idx` is 0 for the first window of a run and goes up by one for each window after it.
- R6: A run with `num_win` = N > 0 delivers exactly N windows and accepts exactly N+3 elements. After that, `in_ready` stays low.
- R7: `done` rises only after the handshake of the last window, and it stays high while `go` stays high. When N = 0, `done` rises without any element being accepted. While `done` is high, `in_ready` and `out_valid` are low.
- R8: While `out_valid` is high and `out_ready` is low, the window and its index hold steady, and no further window is formed. No window is lost or duplicated under any pattern of stalls.
- R9: Lowering `go` clears `done` and any pending window. The next run starts again at index 0 and needs a fresh warm-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Run enable from the controlling software |
| num_win | input | CNT_W | Number of windows to deliver, sampled as the run starts |
| in_valid | input | 1 | Stream element valid |
| in_data | input | DW | Stream element, ascending address order |
| in_ready | output | 1 | Block accepts the element this cycle |
| out_valid | output | 1 | Window valid |
| out_ready | input | 1 | Consumer group takes the window |
| out_win | output | WIN*DW | Window, lowest address in the lowest slice |
| out_idx | output | CNT_W | Consumer index of the window |
| done | output | 1 | All windows of the run delivered |

## Verification
A stale or misordered tap in the register chain would put a wrong element into some slice of the very first window after warm-up. It would then keep doing so on every window after that. An off-by-one in the accepted-element counter would show up at the end of a run, as an extra or missing accepted element or window, or as a done flag that rises too early. A fault in the stall path would show up within one cycle of a stall, as a changed window or a skipped index. Comparing every delivered window against elements computed arithmetically, under free-flowing, bursty and heavily stalled patterns, exposes each of these right away.

// File: rtl/win_pkg.sv
package win_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } win_state_t;
endpackage

// File: rtl/win_shift_chain.sv
module win_shift_chain #(
  parameter int DW  = 16,
  parameter int WIN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift,
  input  logic [DW-1:0]     din,
  output logic [WIN*DW-1:0] window
);
  localparam int TAPS = WIN - 1;

  logic [DW-1:0] taps [TAPS];

  for (genvar j = 0; j < TAPS; j++) begin : g_tap
    if (j == TAPS - 1) begin : g_last
      always_ff @(posedge clk) begin
        if (rst) taps[j] <= '0;
        else if (shift) taps[j] <= din;
      end
    end else begin : g_mid
      always_ff @(posedge clk) begin
        if (rst) taps[j] <= '0;
        else if (shift) taps[j] <= taps[j+1];
      end
    end
    assign window[j*DW +: DW] = taps[j];
  end

  assign window[TAPS*DW +: DW] = din;
endmodule

// File: rtl/win_ctrl.sv
module win_ctrl
  import win_pkg::*;
#(
  parameter int WIN   = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [CNT_W-1:0] num_win,
  input  logic             in_valid,
  input  logic             out_valid,
  input  logic             out_ready,
  output logic             in_ready,
  output logic             emit,
  output logic [CNT_W-1:0] emit_idx,
  output logic             clr,
  output logic             done
);
  localparam int IC_W = CNT_W + 1;
  localparam logic [IC_W-1:0] FILL = IC_W'(WIN - 1);

  win_state_t       state;
  logic [CNT_W-1:0] lim;
  logic [IC_W-1:0]  in_cnt;
  logic [CNT_W-1:0] out_cnt;
  logic [IC_W-1:0]  need;
  logic             accept, out_fire, last_fire, warm, room;

  assign need      = {1'b0, lim} + FILL;
  assign warm      = in_cnt >= FILL;
  assign room      = !warm || !out_valid || out_ready;
  assign in_ready  = go && (state == ST_RUN) && (in_cnt < need) && room;
  assign accept    = in_valid && in_ready;
  assign emit      = accept && warm;
  assign emit_idx  = CNT_W'(in_cnt - FILL);
  assign out_fire  = out_valid && out_ready;
  assign last_fire = out_fire && (out_cnt == lim - CNT_W'(1));
  assign clr       = !go || (state != ST_RUN);
  assign done      = (state == ST_FIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      lim     <= '0;
      in_cnt  <= '0;
      out_cnt <= '0;
    end else if (!go) begin
      state   <= ST_IDLE;
      in_cnt  <= '0;
      out_cnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          lim     <= num_win;
          in_cnt  <= '0;
          out_cnt <= '0;
          state   <= (num_win == '0) ? ST_FIN : ST_RUN;
        end
        ST_RUN: begin
          if (accept) in_cnt <= in_cnt + IC_W'(1);
          if (out_fire) out_cnt <= out_cnt + CNT_W'(1);
          if (last_fire) state <= ST_FIN;
        end
        default: state <= ST_FIN;
      endcase
    end
  end

  // R6: the accepted-element count never passes the run's element budget
  a_r6_no_overrun: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN) |-> (in_cnt <= need));

  // R7: no window is taken once the run is finished
  a_r7_fin_quiet: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FIN) |-> !out_valid);
endmodule

// File: rtl/win_out_reg.sv
module win_out_reg #(
  parameter int DW    = 16,
  parameter int WIN   = 4,
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              load,
  input  logic [WIN*DW-1:0] win_in,
  input  logic [CNT_W-1:0]  idx_in,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WIN*DW-1:0] out_win,
  output logic [CNT_W-1:0]  out_idx
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_win   <= '0;
      out_idx   <= '0;
    end else if (clr) begin
      out_valid <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_win   <= win_in;
      out_idx   <= idx_in;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R8: a stalled window is held unchanged
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !clr) |=> (out_valid && $stable(out_win) && $stable(out_idx)));
endmodule

// File: rtl/win_smart_buffer.sv
module win_smart_buffer #(
  parameter int DW    = 16,
  parameter int WIN   = 4,
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [CNT_W-1:0]  num_win,
  input  logic              in_valid,
  input  logic [DW-1:0]     in_data,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WIN*DW-1:0] out_win,
  output logic [CNT_W-1:0]  out_idx,
  output logic              done
);
  logic              emit, clr, shift;
  logic [CNT_W-1:0]  emit_idx;
  logic [WIN*DW-1:0] win_now;

  assign shift = in_valid && in_ready;

  win_ctrl #(.WIN(WIN), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .go(go), .num_win(num_win),
    .in_valid(in_valid), .out_valid(out_valid), .out_ready(out_ready),
    .in_ready(in_ready), .emit(emit), .emit_idx(emit_idx),
    .clr(clr), .done(done)
  );

  win_shift_chain #(.DW(DW), .WIN(WIN)) u_chain (
    .clk(clk), .rst(rst), .shift(shift), .din(in_data), .window(win_now)
  );

  win_out_reg #(.DW(DW), .WIN(WIN), .CNT_W(CNT_W)) u_out (
    .clk(clk), .rst(rst), .clr(clr), .load(emit),
    .win_in(win_now), .idx_in(emit_idx), .out_ready(out_ready),
    .out_valid(out_valid), .out_win(out_win), .out_idx(out_idx)
  );

  // R2: with the enable low nothing moves on the next cycle
  a_r2_idle: assert property (@(posedge clk) disable iff (rst)
    !go |=> (!out_valid && !done));

  // R3: a new window is only ever produced by an accepted element
  a_r3_from_input: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  // R7: the finished state takes no input and shows no window
  a_r7_done_stop: assert property (@(posedge clk) disable iff (rst)
    done |-> (!in_ready && !out_valid));

  // R1: reset leaves the outputs quiet
  a_r1_reset: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !done));
endmodule

// File: tb/sim_win_smart_buffer.sv
`timescale 1ns/1ps
module sim_win_smart_buffer;
  localparam int DW = 8;
  localparam int WIN = 4;
  localparam int CNT_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic go = 1'b0;
  logic [CNT_W-1:0] num_win = '0;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_ready;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [WIN*DW-1:0] out_win;
  logic [CNT_W-1:0] out_idx;
  logic done;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  win_smart_buffer #(.DW(DW), .WIN(WIN), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .go(go), .num_win(num_win),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_win(out_win),
    .out_idx(out_idx), .done(done)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  function automatic logic [DW-1:0] elem(int k, int r);
    return DW'((k * 37 + r * 11 + 5) & 255);
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic run(int n, int p, int r);
    int acc = 0;
    int wc = 0;
    bit fin = 0;
    bit held = 0;
    logic [WIN*DW-1:0] hw = '0;
    logic [CNT_W-1:0] hi = '0;
    logic [WIN*DW-1:0] ew;
    num_win = CNT_W'(n);
    go = 1'b1;
    for (int c = 0; c < 400 && !fin; c++) begin
      @(negedge clk);
      if (held) begin
        chk(out_valid && out_win == hw && out_idx == hi, "R8 stall hold",
            longint'(out_win), longint'(hw));
        held = 0;
      end
      if (done) begin
        chk(wc == n, "R7 done after last window", wc, n);
        fin = 1;
      end else begin
        in_valid = (p == 0) ? 1'b1 : ((c % 3) != 1);
        out_ready = (p == 0) ? 1'b1 : (p == 1) ? ((c % 4) != 0) : ((c % 3) == 0);
        in_data = elem(acc, r);
        #1;
        if (out_valid) begin
          if (wc == 0) chk(acc >= WIN, "R3 warm-up", acc, WIN);
          for (int e = 0; e < WIN; e++) ew[e*DW +: DW] = elem(wc + e, r);
          chk(out_win == ew, "R4 window contents", longint'(out_win), longint'(ew));
          chk(out_idx == CNT_W'(wc), "R5 index", out_idx, wc);
          if (out_ready) wc++;
          else begin held = 1; hw = out_win; hi = out_idx; end
        end
        if (in_valid && in_ready) acc++;
      end
    end
    chk(fin, "R7 done raised", fin, 1);
    chk(wc == n, "R6 window count", wc, n);
    chk(acc == ((n == 0) ? 0 : n + WIN - 1), "R6 element count", acc, (n == 0) ? 0 : n + WIN - 1);
    in_valid = 1'b1;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(done && !in_ready && !out_valid, "R7 done holds, input stopped",
        {done, in_ready, out_valid}, 3'b100);
    go = 1'b0;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk(!done && !out_valid, "R9 cleared by go low", {done, out_valid}, 2'b00);
  endtask

  initial begin
    int r = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!out_valid && !done && !in_ready, "R1 reset state",
        {out_valid, done, in_ready}, 3'b000);
    in_valid = 1'b1;
    out_ready = 1'b1;
    num_win = 4'd5;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      chk(!in_ready && !out_valid, "R2 idle ignores input", {in_ready, out_valid}, 2'b00);
    end
    in_valid = 1'b0;
    for (int p = 0; p < 3; p++) begin
      for (int n = 0; n < 16; n++) begin
        run(n, p, r);
        r++;
      end
    end
    // R9: abort mid-run, then a fresh run starts at index 0
    num_win = 4'd6;
    go = 1'b1;
    in_valid = 1'b1;
    out_ready = 1'b0;
    repeat (8) @(negedge clk);
    go = 1'b0;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk(!out_valid && !done, "R9 abort clears window", {out_valid, done}, 2'b00);
    run(3, 0, r);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule